// File: doc/BRIEF.md
# Cache Tag Store with Hit Compare

This block keeps the address tags and line status for a direct-mapped secondary cache. Every set holds one tag and three status flags: valid, dirty and write-through. A set address selects the entry. A clocked write stores a new tag and new flags. An output-enabled read returns the stored tag. A single-cycle clear wipes the flags of every set but leaves the stored tags in place.

A combinational compare output tells the cache controller whether an incoming address tag hits the selected set. A hit requires the stored valid flag to be set. The bidirectional tag bus of a discrete tag memory appears here as three separate signals: an input bus, an output bus and an output-enable flag. The status flags have their own output-enable flag.

The control inputs are active low. The block raises a flag when it sees one of the two forbidden control combinations. When that happens, storage is left alone.

Top module: `tagram_top`

## Requirements
- R1: On a rising clock edge with we_n=0, oe_n=1 and clr_n=1, the entry at set_idx takes tag_in, vld_in, dty_in and wt_in, and keeps them until it is rewritten or cleared.
- R2: While we_n=0, oe_n=1 and clr_n=1, the outputs pass the write data through: tag_oe=1, tag_out=tag_in, stat_oe=1, the status outputs equal vld_in/dty_in/wt_in, and match=0.
- R3: With we_n=1 and clr_n=1, tag_oe equals the inverse of oe_n, and tag_out is the stored tag of set_idx when tag_oe=1. tag_out is 0 whenever tag_oe=0.
- R4: With we_n=1 and clr_n=1, stat_oe=1 and vld_out/dty_out/wt_out show the stored flags of set_idx.
- R5: match is 0 whenever the stored valid flag of set_idx is 0, whatever tag_in holds.
- R6: With we_n=1 and clr_n=1 and the stored valid flag set, match is 1 exactly when tag_in equals the stored tag of set_idx.
- R7: A rising edge with clr_n=0 and we_n=1 zeroes the valid, dirty and write-through flags of every set and keeps the stored tags. While clr_n=0 and we_n=1: tag_oe=0, stat_oe=0, match=0, and all data outputs are 0.
- R8: we_n=0 together with oe_n=0 sets illegal=1, and the following edge changes no entry.
- R9: we_n=0 together with clr_n=0 sets illegal=1, and the following edge changes no entry. While illegal=1: tag_oe=0, match=0, and the status outputs show the stored flags with stat_oe=1.
- R10: After reset, every set has all three flags at 0 and a tag of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| set_idx | input | IDX_W | Set address |
| tag_in | input | TAG_W | Incoming tag, used for both write and compare |
| vld_in | input | 1 | Valid flag to write |
| dty_in | input | 1 | Dirty flag to write |
| wt_in | input | 1 | Write-through flag to write |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Tag output enable, active low |
| clr_n | input | 1 | Clear all flags, active low |
| tag_out | output | TAG_W | Tag output bus |
| tag_oe | output | 1 | Tag output bus is being driven |
| vld_out | output | 1 | Valid flag output |
| dty_out | output | 1 | Dirty flag output |
| wt_out | output | 1 | Write-through flag output |
| stat_oe | output | 1 | Status outputs are being driven |
| match | output | 1 | Tag hit on the selected set |
| illegal | output | 1 | Forbidden control combination seen |

## Verification
The bench targets a tag that matches a set whose valid flag is clear. A comparator that ignores the valid flag would report a false hit there. It also checks tags that differ in only the lowest bit and writes at the first and last set, where a short comparator or a bad index decode would hit wrongly or store into the wrong set. Both forbidden combinations are followed by a readback of the entry involved, so a design that still wrote would show the new data. After a clear, the bench reads tags and flags from several sets: a clear that reached only the selected set, or that also wiped the tags, shows up as a wrong flag or a wrong tag.

// File: rtl/tagram_pkg.sv
package tagram_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_CLEAR = 2'd2,
        OP_BAD   = 2'd3
    } op_e;

    typedef struct packed {
        logic vld;
        logic dty;
        logic wt;
    } stat_t;

endpackage

// File: rtl/tagram_ctrl.sv
module tagram_ctrl
    import tagram_pkg::*;
(
    input  logic we_n,
    input  logic oe_n,
    input  logic clr_n,
    output op_e  op,
    output logic rd_en,
    output logic bad
);

    always_comb begin
        bad   = 1'b0;
        rd_en = 1'b0;
        op    = OP_IDLE;
        if (!we_n && (!oe_n || !clr_n)) begin
            bad = 1'b1;
            op  = OP_BAD;
        end else if (!we_n) begin
            op = OP_WRITE;
        end else if (!clr_n) begin
            op = OP_CLEAR;
        end else begin
            op    = OP_IDLE;
            rd_en = !oe_n;
        end
    end

endmodule

// File: rtl/tagram_store.sv
module tagram_store
    import tagram_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int TAG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  op_e              op,
    input  logic [IDX_W-1:0] idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  stat_t            wr_stat,
    output logic [TAG_W-1:0] rd_tag,
    output stat_t            rd_stat
);

    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic  [DEPTH-1:0][TAG_W-1:0] tag;
        stat_t [DEPTH-1:0]            st;
    } store_t;

    store_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (op)
            OP_WRITE: begin
                s_d.tag[idx] = wr_tag;
                s_d.st[idx]  = wr_stat;
            end
            OP_CLEAR: begin
                for (int i = 0; i < DEPTH; i++) begin
                    s_d.st[i] = '0;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_tag  = s_q.tag[idx];
    assign rd_stat = s_q.st[idx];

endmodule

// File: rtl/tagram_cmp.sv
module tagram_cmp #(
    parameter int TAG_W = 16
) (
    input  logic [TAG_W-1:0] probe,
    input  logic [TAG_W-1:0] stored,
    input  logic             stored_vld,
    input  logic             en,
    output logic             hit
);

    logic [TAG_W-1:0] bit_eq;

    for (genvar b = 0; b < TAG_W; b++) begin : g_bit
        assign bit_eq[b] = ~(probe[b] ^ stored[b]);
    end

    assign hit = en && stored_vld && (&bit_eq);

endmodule

// File: rtl/tagram_top.sv
module tagram_top
    import tagram_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int TAG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] set_idx,
    input  logic [TAG_W-1:0] tag_in,
    input  logic             vld_in,
    input  logic             dty_in,
    input  logic             wt_in,
    input  logic             we_n,
    input  logic             oe_n,
    input  logic             clr_n,
    output logic [TAG_W-1:0] tag_out,
    output logic             tag_oe,
    output logic             vld_out,
    output logic             dty_out,
    output logic             wt_out,
    output logic             stat_oe,
    output logic             match,
    output logic             illegal
);

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic             tag_en;
        stat_t            st;
        logic             st_en;
    } outs_t;

    op_e              op;
    logic             rd_en;
    logic             bad;
    logic [TAG_W-1:0] rd_tag;
    stat_t            rd_stat;
    stat_t            wr_stat;
    logic             cmp_en;
    logic             hit;
    outs_t            o_d;

    assign wr_stat = '{vld: vld_in, dty: dty_in, wt: wt_in};

    tagram_ctrl u_ctrl (
        .we_n  (we_n),
        .oe_n  (oe_n),
        .clr_n (clr_n),
        .op    (op),
        .rd_en (rd_en),
        .bad   (bad)
    );

    tagram_store #(
        .IDX_W (IDX_W),
        .TAG_W (TAG_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .idx     (set_idx),
        .wr_tag  (tag_in),
        .wr_stat (wr_stat),
        .rd_tag  (rd_tag),
        .rd_stat (rd_stat)
    );

    assign cmp_en = (op == OP_IDLE);

    tagram_cmp #(
        .TAG_W (TAG_W)
    ) u_cmp (
        .probe      (tag_in),
        .stored     (rd_tag),
        .stored_vld (rd_stat.vld),
        .en         (cmp_en),
        .hit        (hit)
    );

    always_comb begin
        o_d = '0;
        case (op)
            OP_WRITE: begin
                o_d.tag    = tag_in;
                o_d.tag_en = 1'b1;
                o_d.st     = wr_stat;
                o_d.st_en  = 1'b1;
            end
            OP_CLEAR: begin
                o_d = '0;
            end
            OP_BAD: begin
                o_d.st    = rd_stat;
                o_d.st_en = 1'b1;
            end
            default: begin
                o_d.tag_en = rd_en;
                o_d.tag    = rd_en ? rd_tag : '0;
                o_d.st     = rd_stat;
                o_d.st_en  = 1'b1;
            end
        endcase
    end

    assign tag_out = o_d.tag;
    assign tag_oe  = o_d.tag_en;
    assign vld_out = o_d.st.vld;
    assign dty_out = o_d.st.dty;
    assign wt_out  = o_d.st.wt;
    assign stat_oe = o_d.st_en;
    assign match   = hit;
    assign illegal = bad;

endmodule

// File: rtl/tagram_chk.sv
module tagram_chk #(
    parameter int IDX_W = 8,
    parameter int TAG_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [IDX_W-1:0] set_idx,
    input logic [TAG_W-1:0] tag_in,
    input logic             vld_in,
    input logic             we_n,
    input logic             oe_n,
    input logic             clr_n,
    input logic [TAG_W-1:0] tag_out,
    input logic             tag_oe,
    input logic             vld_out,
    input logic             dty_out,
    input logic             wt_out,
    input logic             stat_oe,
    input logic             match,
    input logic             illegal
);

    p_write_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && oe_n && clr_n) |-> (tag_oe && tag_out == tag_in && vld_out == vld_in && !match));

    p_write_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!we_n && oe_n && clr_n) && set_idx == $past(set_idx) && we_n && clr_n && !oe_n)
        |-> (tag_out == $past(tag_in) && vld_out == $past(vld_in)));

    p_hit_needs_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> (vld_out && stat_oe));

    p_hit_tag_equal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !oe_n) |-> (tag_out == tag_in));

    p_clear_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_n && we_n) |-> (!tag_oe && !stat_oe && !match));

    p_clear_wipes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!clr_n && we_n) && clr_n && we_n) |-> (!vld_out && !dty_out && !wt_out));

    p_bad_oe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && !oe_n) |-> (illegal && !tag_oe));

    p_bad_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && !clr_n) |-> (illegal && !match));

endmodule

bind tagram_top tagram_chk #(
    .IDX_W (IDX_W),
    .TAG_W (TAG_W)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_idx (set_idx),
    .tag_in  (tag_in),
    .vld_in  (vld_in),
    .we_n    (we_n),
    .oe_n    (oe_n),
    .clr_n   (clr_n),
    .tag_out (tag_out),
    .tag_oe  (tag_oe),
    .vld_out (vld_out),
    .dty_out (dty_out),
    .wt_out  (wt_out),
    .stat_oe (stat_oe),
    .match   (match),
    .illegal (illegal)
);

// File: tb/tagram_top_tb_top.sv
module tagram_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int IDX_W      = 8;
    localparam int TAG_W      = 16;
    localparam int DEPTH      = 1 << IDX_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [IDX_W-1:0] set_idx = '0;
    logic [TAG_W-1:0] tag_in = '0;
    logic             vld_in = 1'b0, dty_in = 1'b0, wt_in = 1'b0;
    logic             we_n = 1'b1, oe_n = 1'b1, clr_n = 1'b1;
    logic [TAG_W-1:0] tag_out;
    logic             tag_oe, vld_out, dty_out, wt_out, stat_oe, match, illegal;

    always #(CLK_PERIOD/2) clk = ~clk;

    tagram_top #(.IDX_W(IDX_W), .TAG_W(TAG_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .tag_in(tag_in),
        .vld_in(vld_in), .dty_in(dty_in), .wt_in(wt_in),
        .we_n(we_n), .oe_n(oe_n), .clr_n(clr_n),
        .tag_out(tag_out), .tag_oe(tag_oe), .vld_out(vld_out), .dty_out(dty_out),
        .wt_out(wt_out), .stat_oe(stat_oe), .match(match), .illegal(illegal)
    );

    typedef struct {
        logic [TAG_W-1:0] tag;
        logic             tag_en;
        logic [2:0]       st;
        logic             st_en;
        logic             hit;
        logic             bad;
        string            req;
    } exp_t;

    exp_t             sb_q[$];
    logic [TAG_W-1:0] m_tag [DEPTH];
    logic [2:0]       m_st  [DEPTH];
    int               checks = 0;
    int               errors = 0;
    bit               done = 0;

    function automatic exp_t predict(string req);
        exp_t e;
        logic wr, clr, bad;
        wr  = !we_n && oe_n && clr_n;
        clr = we_n && !clr_n;
        bad = !we_n && (!oe_n || !clr_n);
        e.req = req; e.bad = bad;
        e.tag = '0; e.tag_en = 0; e.st = '0; e.st_en = 0; e.hit = 0;
        if (wr) begin
            e.tag = tag_in; e.tag_en = 1; e.st = {vld_in, dty_in, wt_in}; e.st_en = 1;
        end else if (clr) begin
            // everything quiet
        end else if (bad) begin
            e.st = m_st[set_idx]; e.st_en = 1;
        end else begin
            e.tag_en = !oe_n;
            e.tag    = !oe_n ? m_tag[set_idx] : '0;
            e.st     = m_st[set_idx];
            e.st_en  = 1;
            e.hit    = m_st[set_idx][2] && (tag_in == m_tag[set_idx]);
        end
        return e;
    endfunction

    task automatic step(input logic [IDX_W-1:0] idx, input logic [TAG_W-1:0] t,
                        input logic [2:0] st, input logic w, input logic o,
                        input logic c, input string req);
        @(negedge clk);
        set_idx = idx; tag_in = t; {vld_in, dty_in, wt_in} = st;
        we_n = w; oe_n = o; clr_n = c;
        #1;
        sb_q.push_back(predict(req));
        @(posedge clk);
        if (!we_n && oe_n && clr_n) begin
            m_tag[set_idx] = tag_in;
            m_st[set_idx]  = {vld_in, dty_in, wt_in};
        end else if (we_n && !clr_n) begin
            for (int i = 0; i < DEPTH; i++) m_st[i] = '0;
        end
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            wait (sb_q.size() != 0);
            e = sb_q.pop_front();
            checks++;
            if (tag_oe !== e.tag_en || tag_out !== e.tag || stat_oe !== e.st_en ||
                {vld_out, dty_out, wt_out} !== e.st || match !== e.hit || illegal !== e.bad) begin
                errors++;
                $display("FAIL %s: got oe=%b tag=%h soe=%b st=%b hit=%b bad=%b exp oe=%b tag=%h soe=%b st=%b hit=%b bad=%b",
                         e.req, tag_oe, tag_out, stat_oe, {vld_out, dty_out, wt_out}, match, illegal,
                         e.tag_en, e.tag, e.st_en, e.st, e.hit, e.bad);
            end
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : driver
        for (int i = 0; i < DEPTH; i++) begin m_tag[i] = '0; m_st[i] = '0; end
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R10 reset state, R5 tag equal but invalid
        step(8'd0,   16'h0000, 3'b000, 1, 0, 1, "R10 R5 reset entry");
        step(8'd200, 16'h0000, 3'b000, 1, 1, 1, "R10 R4 reset other entry");
        // R2 pass-through and R1 storage
        step(8'd5,   16'hA5A5, 3'b101, 0, 1, 1, "R2 write pass-through");
        step(8'd5,   16'hA5A5, 3'b000, 1, 0, 1, "R1 R3 R6 readback and hit");
        step(8'd5,   16'hA5A4, 3'b000, 1, 0, 1, "R6 lsb mismatch");
        step(8'd5,   16'hA5A5, 3'b000, 1, 1, 1, "R3 tag bus off");
        step(8'd255, 16'hFFFF, 3'b110, 0, 1, 1, "R2 write last set");
        step(8'd0,   16'h1234, 3'b011, 0, 1, 1, "R2 write first set invalid");
        step(8'd255, 16'hFFFF, 3'b000, 1, 0, 1, "R1 R6 last set hit");
        step(8'd0,   16'h1234, 3'b000, 1, 0, 1, "R5 R4 invalid no hit");
        step(8'd254, 16'hFFFF, 3'b000, 1, 0, 1, "R4 R5 neighbour untouched");
        // R8 illegal write with output enable
        step(8'd5,   16'h0000, 3'b011, 0, 0, 1, "R8 flag");
        step(8'd5,   16'hA5A5, 3'b000, 1, 0, 1, "R8 entry kept");
        // R9 illegal write with clear
        step(8'd255, 16'h0F0F, 3'b000, 0, 1, 0, "R9 flag");
        step(8'd255, 16'hFFFF, 3'b000, 1, 0, 1, "R9 entry kept");
        step(8'd5,   16'hA5A5, 3'b000, 1, 1, 1, "R9 flags kept other set");
        // R7 clear
        step(8'd5,   16'hA5A5, 3'b000, 1, 0, 0, "R7 outputs quiet");
        step(8'd5,   16'hA5A5, 3'b000, 1, 0, 1, "R7 flags wiped tag kept");
        step(8'd255, 16'hFFFF, 3'b000, 1, 0, 1, "R7 last set wiped");
        step(8'd0,   16'h1234, 3'b000, 1, 0, 1, "R7 first set wiped");
        // rewrite after clear
        step(8'd77,  16'h5A5A, 3'b111, 0, 1, 1, "R2 write after clear");
        step(8'd77,  16'h5A5A, 3'b000, 1, 1, 1, "R1 R6 hit after clear");
        step(8'd77,  16'hDA5A, 3'b000, 1, 0, 1, "R6 msb mismatch");
        @(negedge clk);
        wait (sb_q.size() == 0);
        #1;
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule